// File: doc/BRIEF.md
# Dual-Bank Mixed-Trigger Interrupt Controller

This block gathers 64 interrupt request lines into two banks of 32 and drives one active-high interrupt line to a processor. Every bit position is either edge-type or level-type. The choice is fixed by a constant pattern that is applied at reset. Edge-type bits latch a rising edge into a sticky event register. Level-type bits never latch and stay pending for as long as their input is high.

Software reaches each bank through a small synchronous 32-bit register bus. It can read the latched events, the live input levels and the enable mask. It can write the mask and acknowledge events. The processor line is high whenever some bank has a bit that is both enabled and active. A bit is active when it is a latched event, or when it is level-type with its input high.

Input lines may be asynchronous. They pass through a two-stage synchronizer before they are used.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: The bank index is ((addr & 0xFFF) - 0x010) >> 4, computed in 12 bits with wraparound. Only index 0 (addresses 0x010-0x01F) and index 1 (0x020-0x02F) are valid. A read of any other address returns zero, and a write to it changes nothing.
- R2: Within a bank, addr[3:0] selects the register. 0x0 reads the event register. 0x4 reads and writes the mask. 0x8 is a write-only acknowledge that reads as zero. 0xC reads the level register. Every other offset reads as zero and ignores writes.
- R3: Input n feeds bank (1 - (n >> 5)) at bit (n & 31). Inputs 0-31 therefore land in bank 1, and inputs 32-63 in bank 0.
- R4: An edge-type bit sets its event bit on a rising edge of its synchronized input. An input held high latches only once, even after an acknowledge. A falling edge leaves the event bit unchanged.
- R5: The level register holds the synchronized input value. It changes on the third rising clock edge that samples the new input value.
- R6: An acknowledge write clears every event bit whose data bit is 1. Data bits at level-type positions are ignored.
- R7: When a new rising edge and an acknowledge of the same bit land on the same clock edge, the event bit stays set.
- R8: The level-type pattern is zero for bank 0 and 0x1FF00000 for bank 1. A level-type bit never sets its event bit, and it is active while its level bit is 1.
- R9: cpu_irq is registered. It equals, one clock later, whether (events | (levels & level_type)) & mask is nonzero in either bank. A mask write therefore shows on cpu_irq one cycle after the write.
- R10: After reset, the mask, event and level registers read zero and cpu_irq is low.
- R11: bus_rdata holds the selected value in the cycle after a read strobe. It is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| irq_in | input | 64 | Interrupt request lines; may be asynchronous to clk |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read strobe |
| cpu_irq | output | 1 | Active-high interrupt to the processor |

## Verification
The bench first drives single inputs from each half of the input range. This tells the reverse bank mapping apart from a straight one, and the edge-type bits apart from the level-type bits in the same bank. It then holds an edge input high across an acknowledge, which separates true edge detection from level sampling. It also acknowledges a level-type bit, which shows that the data masking works. One sequence lines up a fresh edge with an acknowledge on the same clock edge, to show which of the two wins. Accesses to invalid bank indices and to unused offsets show that the address decode has no holes. A long stretch of random input toggles and random bus traffic over the whole 0x00-0x3F window is then compared, cycle by cycle, against a behavioural model.

// File: rtl/dbic_pkg.sv
`timescale 1ns/1ps
package dbic_pkg;
  // register offsets within a bank (addr[3:0])
  localparam logic [3:0] OFS_EVT = 4'h0;
  localparam logic [3:0] OFS_MSK = 4'h4;
  localparam logic [3:0] OFS_ACK = 4'h8;
  localparam logic [3:0] OFS_LVL = 4'hC;
  // address of bank index 0
  localparam logic [11:0] BANK_BASE = 12'h010;
endpackage

// File: rtl/dbic_sync.sv
`timescale 1ns/1ps
module dbic_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dbic_decode.sv
`timescale 1ns/1ps
module dbic_decode
  import dbic_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 2,
  parameter int SEL_W     = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SEL_W-1:0]  sel,
  output logic [3:0]        ofs
);
  localparam int IDX_W = ADDR_W - 4;

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    rel = addr - ADDR_W'(BANK_BASE);
    idx = rel[ADDR_W-1:4];
    hit = (idx < IDX_W'(NUM_BANKS));
    sel = idx[SEL_W-1:0];
    ofs = rel[3:0];
  end
endmodule

// File: rtl/dbic_bank.sv
`timescale 1ns/1ps
module dbic_bank #(
  parameter int           W  = 32,
  parameter logic [W-1:0] LT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic         msk_we,
  input  logic         ack_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] msk_o,
  output logic         pend_o
);
  logic [W-1:0] evt_q, evt_d;
  logic [W-1:0] lvl_q;
  logic [W-1:0] msk_q;
  logic [W-1:0] ack_clr, rise;

  // next state: acknowledge first, then a fresh edge sets (set wins)
  always_comb begin
    ack_clr = ack_we ? (wdata & ~LT) : '0;
    rise    = smp & ~lvl_q & ~LT;
    evt_d   = (evt_q & ~ack_clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      lvl_q <= '0;
    end else begin
      evt_q <= evt_d;
      lvl_q <= smp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msk_q <= '0;
    else if (msk_we) msk_q <= wdata;
  end

  assign evt_o  = evt_q;
  assign lvl_o  = lvl_q;
  assign msk_o  = msk_q;
  assign pend_o = |((evt_q | (lvl_q & LT)) & msk_q);
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
`timescale 1ns/1ps
module dual_bank_irq_ctrl
  import dbic_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] LT_CFG = {32'h1FF0_0000, 32'h0000_0000}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_in,
  input  logic                        bus_req,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic                        cpu_irq
);
  localparam int NUM_IN = NUM_BANKS * BANK_W;
  localparam int SEL_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [NUM_IN-1:0] irq_s;

  dbic_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_core_n), .d(irq_in), .q(irq_s)
  );

  logic             hit;
  logic [SEL_W-1:0] sel;
  logic [3:0]       ofs;

  dbic_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) dec_i (
    .addr(bus_addr), .hit(hit), .sel(sel), .ofs(ofs)
  );

  logic [BANK_W-1:0]  evt_arr [NUM_BANKS];
  logic [BANK_W-1:0]  lvl_arr [NUM_BANKS];
  logic [BANK_W-1:0]  msk_arr [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend;
  logic [NUM_IN-1:0]  evt_all, lvl_all, msk_all;

  logic wr_hit;
  assign wr_hit = bus_req & bus_we & hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic me, ae;
    assign me = wr_hit & (sel == SEL_W'(b)) & (ofs == OFS_MSK);
    assign ae = wr_hit & (sel == SEL_W'(b)) & (ofs == OFS_ACK);

    // inputs map to banks in reverse order
    dbic_bank #(.W(BANK_W), .LT(LT_CFG[b*BANK_W +: BANK_W])) bank_i (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .smp    (irq_s[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
      .msk_we (me),
      .ack_we (ae),
      .wdata  (bus_wdata),
      .evt_o  (evt_arr[b]),
      .lvl_o  (lvl_arr[b]),
      .msk_o  (msk_arr[b]),
      .pend_o (pend[b])
    );

    assign evt_all[b*BANK_W +: BANK_W] = evt_arr[b];
    assign lvl_all[b*BANK_W +: BANK_W] = lvl_arr[b];
    assign msk_all[b*BANK_W +: BANK_W] = msk_arr[b];
  end

  // read path and interrupt output: next state
  logic [BANK_W-1:0] rd_d;
  logic              irq_d;

  always_comb begin
    rd_d = '0;
    if (bus_req && !bus_we && hit) begin
      unique case (ofs)
        OFS_EVT: rd_d = evt_arr[sel];
        OFS_MSK: rd_d = msk_arr[sel];
        OFS_LVL: rd_d = lvl_arr[sel];
        default: rd_d = '0;
      endcase
    end
    irq_d = |pend;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      bus_rdata <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      bus_rdata <= rd_d;
      cpu_irq   <= irq_d;
    end
  end
endmodule

// File: rtl/dbic_chk.sv
`timescale 1ns/1ps
module dbic_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 12,
  parameter logic [NUM_BANKS*BANK_W-1:0] LT_CFG = '0
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_req,
  input logic                        bus_we,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [BANK_W-1:0]           bus_wdata,
  input logic [BANK_W-1:0]           bus_rdata,
  input logic                        cpu_irq,
  input logic [NUM_BANKS*BANK_W-1:0] evt_all,
  input logic [NUM_BANKS*BANK_W-1:0] lvl_all,
  input logic [NUM_BANKS*BANK_W-1:0] msk_all
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(16 + 16*NUM_BANKS);

  // R8: a level-type position never holds an event
  a_r8_lt_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_all & LT_CFG) == '0);

  // R4: an event bit only appears together with a high level bit
  a_r4_event_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_all & ~$past(evt_all) & ~lvl_all) == '0);

  // R9: mask write to bank 0 is in place one cycle later
  a_r9_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == ADDR_W'(12'h014))
    |=> msk_all[BANK_W-1:0] == $past(bus_wdata));

  // R9: output follows the pending condition one cycle later
  a_r9_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cpu_irq == $past(|((evt_all | (lvl_all & LT_CFG)) & msk_all)));

  // R1: invalid bank index reads zero
  a_r1_bad_bank_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && (bus_addr < LO || bus_addr >= HI)) |=> bus_rdata == '0);

  // R11: read data is zero after a cycle with no read
  a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> bus_rdata == '0);
endmodule

bind dual_bank_irq_ctrl dbic_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .LT_CFG(LT_CFG)
) chk_i (
  .clk(clk), .rst_n(rst_core_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cpu_irq(cpu_irq), .evt_all(evt_all), .lvl_all(lvl_all), .msk_all(msk_all)
);

// File: tb/dual_bank_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_bank_irq_ctrl_tb_top;
  localparam real CLK_PERIOD = 8.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cpu_irq;

  int    checks = 0;
  int    errors = 0;
  bit    cmp_en = 0;
  string cur_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_req(req), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .cpu_irq(cpu_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_s1, m_s2;
  logic [31:0] m_lvl [2];
  logic [31:0] m_evt [2];
  logic [31:0] m_msk [2];
  logic        m_irq;
  logic [31:0] m_rd;
  int          m_cnt;

  function automatic logic [31:0] lt_of(int b);
    return (b == 1) ? 32'h1FF0_0000 : 32'h0;
  endfunction

  task automatic m_zero();
    m_s1 = '0; m_s2 = '0; m_irq = 0; m_rd = '0;
    for (int b = 0; b < 2; b++) begin
      m_lvl[b] = '0; m_evt[b] = '0; m_msk[b] = '0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_zero();
    end else if (m_cnt < 2) begin
      m_cnt++; m_zero();
    end else begin
      logic [31:0] n_evt [2];
      logic [31:0] n_lvl [2];
      logic        n_irq;
      logic [31:0] n_rd;
      int unsigned a;
      int          bk;
      bit          ok;
      n_irq = 0;
      for (int b = 0; b < 2; b++) begin
        if (((m_evt[b] | (m_lvl[b] & lt_of(b))) & m_msk[b]) != 0) n_irq = 1;
        n_evt[b] = m_evt[b];
        n_lvl[b] = m_lvl[b];
      end
      a  = addr;
      ok = (a >= 16) && (a < 48);
      bk = ok ? int'((a - 16) / 16) : 0;
      n_rd = '0;
      if (req && !we && ok) begin
        case (a % 16)
          0:  n_rd = m_evt[bk];
          4:  n_rd = m_msk[bk];
          12: n_rd = m_lvl[bk];
          default: n_rd = '0;
        endcase
      end
      if (req && we && ok && (a % 16) == 8) n_evt[bk] = n_evt[bk] & ~(wdata & ~lt_of(bk));
      for (int n = 0; n < 64; n++) begin
        int b, k;
        b = 1 - n / 32;
        k = n % 32;
        if (m_s2[n] && !m_lvl[b][k] && !lt_of(b)[k]) n_evt[b][k] = 1'b1;
        n_lvl[b][k] = m_s2[n];
      end
      if (req && we && ok && (a % 16) == 4) m_msk[bk] = wdata;
      for (int b = 0; b < 2; b++) begin
        m_evt[b] = n_evt[b];
        m_lvl[b] = n_lvl[b];
      end
      m_irq = n_irq;
      m_rd  = n_rd;
      m_s2  = m_s1;
      m_s1  = irq_in;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk({cur_tag, " cpu_irq"}, {31'b0, cpu_irq}, {31'b0, m_irq});
      chk({cur_tag, " rdata"}, rdata, m_rd);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic wait4();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    cmp_en = 1;

    // R10: reset state
    cur_tag = "R10";
    chk("R10 cpu_irq", {31'b0, cpu_irq}, 32'h0);
    rd_chk(12'h014, 32'h0, "R10 mask0");
    rd_chk(12'h024, 32'h0, "R10 mask1");
    rd_chk(12'h010, 32'h0, "R10 evt0");
    rd_chk(12'h02C, 32'h0, "R10 lvl1");

    // R3 / R5: bank mapping and level register
    cur_tag = "R3";
    irq_in[0] = 1; wait4();
    rd_chk(12'h02C, 32'h1, "R5 input0 level in bank1");
    rd_chk(12'h01C, 32'h0, "R3 input0 absent from bank0");
    irq_in[40] = 1; wait4();
    rd_chk(12'h01C, 32'h100, "R3 input40 bank0 bit8");
    rd_chk(12'h020, 32'h1, "R4 input0 event");
    rd_chk(12'h010, 32'h100, "R4 input40 event");
    chk("R9 masked no irq", {31'b0, cpu_irq}, 32'h0);

    // R9: mask enables output one cycle after write
    cur_tag = "R9";
    bus_wr(12'h024, 32'h1);
    @(negedge clk);
    chk("R9 irq after mask", {31'b0, cpu_irq}, 32'h1);

    // R6 / R4: acknowledge with input held high, then re-edge
    cur_tag = "R4";
    bus_wr(12'h028, 32'h1);
    rd_chk(12'h020, 32'h0, "R6 ack clears event");
    chk("R4 irq low after ack", {31'b0, cpu_irq}, 32'h0);
    wait4();
    rd_chk(12'h020, 32'h0, "R4 held high no relatch");
    irq_in[0] = 0; wait4();
    rd_chk(12'h02C, 32'h0, "R5 level follows fall");
    rd_chk(12'h020, 32'h0, "R4 fall sets nothing");
    irq_in[0] = 1; wait4();
    rd_chk(12'h020, 32'h1, "R4 new edge latches");
    chk("R9 irq on new edge", {31'b0, cpu_irq}, 32'h1);

    // R8 / R6: level-type bits
    cur_tag = "R8";
    bus_wr(12'h028, 32'hFFFF_FFFF);
    rd_chk(12'h020, 32'h0, "R6 ack all");
    bus_wr(12'h024, 32'h0010_0000);
    irq_in[20] = 1; irq_in[52] = 1; wait4();
    rd_chk(12'h020, 32'h0, "R8 level-type no event");
    rd_chk(12'h02C, 32'h0010_0001, "R8 level bits bank1");
    chk("R8 level-type pending", {31'b0, cpu_irq}, 32'h1);
    rd_chk(12'h010, 32'h0010_0100, "R8 bank0 bit20 edge-type");
    cur_tag = "R6";
    bus_wr(12'h028, 32'h0010_0000);
    @(negedge clk);
    chk("R6 ack of level bit ignored", {31'b0, cpu_irq}, 32'h1);
    irq_in[20] = 0; wait4();
    chk("R8 pending ends with level", {31'b0, cpu_irq}, 32'h0);

    // R7: new edge and acknowledge on the same clock edge
    cur_tag = "R7";
    irq_in[33] = 1; wait4();
    irq_in[33] = 0; wait4();
    irq_in[33] = 1;
    @(negedge clk);
    @(negedge clk); req = 1; we = 1; addr = 12'h018; wdata = 32'h2;
    @(negedge clk); req = 0; we = 0;
    rd_chk(12'h010, 32'h0010_0102, "R7 set wins over ack");
    bus_wr(12'h018, 32'h2);
    rd_chk(12'h010, 32'h0010_0100, "R7 later ack clears");

    // R1 / R2: decode holes
    cur_tag = "R1";
    bus_wr(12'h034, 32'hFFFF_FFFF);
    bus_wr(12'h004, 32'hFFFF_FFFF);
    bus_wr(12'h038, 32'hFFFF_FFFF);
    cur_tag = "R2";
    bus_wr(12'h016, 32'hFFFF_FFFF);
    bus_wr(12'h015, 32'hFFFF_FFFF);
    rd_chk(12'h014, 32'h0, "R2 mask0 untouched");
    rd_chk(12'h018, 32'h0, "R2 ack reads zero");
    rd_chk(12'h012, 32'h0, "R2 unused offset");
    rd_chk(12'h01C, 32'h0010_0102, "R5 bank0 levels");
    cur_tag = "R1";
    rd_chk(12'h030, 32'h0, "R1 index2 read");
    rd_chk(12'h000, 32'h0, "R1 wrapped index read");
    rd_chk(12'h03C, 32'h0, "R1 index2 level read");
    rd_chk(12'h010, 32'h0010_0100, "R1 bad-bank ack ignored");
    chk("R1 no irq from bad writes", {31'b0, cpu_irq}, 32'h0);

    // R9 / R11: random traffic against the model
    cur_tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 3 == 0) irq_in[$urandom % 64] ^= 1'b1;
      req   = ($urandom % 4) != 0;
      we    = ($urandom % 2) == 1;
      addr  = 12'($urandom % 64);
      if ($urandom % 4 != 0) addr[1:0] = 2'b00;
      wdata = $urandom;
    end
    @(negedge clk); req = 0; we = 0;
    cur_tag = "R11";
    repeat (3) @(negedge clk);
    cmp_en = 0;
    finish_run();
  end
endmodule